// File: doc/BRIEF.md
# Serial Receiver Status and Interrupt Controller

This block sits between the character assembler of a serial receiver and the processor's register port. Each time the assembler offers a finished character, the block moves it into a one-entry receive buffer. The character is trimmed to the programmed length. Its per-character condition flags (parity, framing, and sync-found or break) are captured together with it. The status byte is frozen while the buffer holds an unread character, so the processor always sees the conditions of the character it is about to read.

A character that arrives while the buffer is still full is dropped, and the loss is held back. Overrun shows only once the processor has read the data. It stays until the status byte is read, and new characters are refused while it is set. A break seen while the buffer is full is held back in the same way. It appears after the data read and does not count as an overrun.

Two level interrupt requests come out: buffer-full and receive-error. An erroneous character raises only the error request. When the error request is masked, that request is shown on the buffer-full line instead.

Top module: `rxstat_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, both interrupt requests are low, `asm_en` is low and no character is accepted, because the receiver-enable bit is 0.
- R2: Status byte layout, bit 7 to bit 0: buffer full, overrun, parity error, frame error, sync/break, match or in-progress, sync strip enable, receiver enable. A pulse on `wr_stat` loads `wr_ctl[1]` into bit 1 and `wr_ctl[0]` into bit 0, and leaves bits 7 to 2 unchanged.
- R3: With receiver enable set, overrun clear and the buffer empty, a pulse on `rx_valid` sets buffer full, stores the data and captures the parity, frame and sync/break inputs into bits 5, 4 and 3. The stored data keeps only the low DATA_W-`len_sel` bits and clears the rest. With DATA_W=8 this gives: 00 keeps 8, 01 keeps 7, 10 keeps 6 and 11 keeps 5.
- R4: A pulse on `rd_data` clears buffer full. While buffer full is set and neither register is read, `buf_data` and status bits 6 to 3 do not change, even when further characters arrive.
- R5: A character offered while the buffer is full is dropped. Overrun (bit 6) stays 0 until the next data read and is set by that read.
- R6: A pulse on `rd_stat` clears overrun. While overrun is set, `asm_en` is low and `rx_valid` is ignored.
- R7: A pulse on `rx_brk` while the buffer is full does not set overrun. It sets bit 3 at the next data read.
- R8: If a character is dropped while the buffer is full and a break then follows before the data read, that data read sets both bit 6 and bit 3.
- R9: A character with no condition flag raises the buffer-full request, which a data read clears. A character with a condition flag raises the error request, which a status read clears, and with `err_ie`=1 it does not raise the buffer-full line.
- R10: With `err_ie`=0, a pending error request is shown on `irq_full`. It stays there after a data read and clears at the status read.
- R11: The enable inputs mask only the request lines. The status flags are unaffected, and enabling a channel later shows a request that is still pending.
- R12: With `async_mode`=1, bit 2 follows `rx_busy` live, even while the status is frozen. With `async_mode`=0, bit 2 is the `rx_match` value captured with the character.
- R13: With receiver enable at 0, both `rx_valid` and `rx_brk` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Assembled character offered (one-cycle pulse) |
| rx_data | input | DATA_W | Assembled character |
| rx_perr | input | 1 | Parity error of the offered character |
| rx_ferr | input | 1 | Frame error of the offered character |
| rx_sfb | input | 1 | Sync-found or break condition of the offered character |
| rx_match | input | 1 | Match indication of the offered character |
| rx_brk | input | 1 | Break detected with no character (one-cycle pulse) |
| rx_busy | input | 1 | Character assembly in progress |
| async_mode | input | 1 | Selects what status bit 2 reports |
| len_sel | input | LEN_W | Character length code |
| rd_data | input | 1 | Data register read strobe |
| rd_stat | input | 1 | Status register read strobe |
| wr_stat | input | 1 | Status register write strobe |
| wr_ctl | input | 2 | Write value: bit 1 sync strip enable, bit 0 receiver enable |
| full_ie | input | 1 | Buffer-full channel enable |
| err_ie | input | 1 | Error channel enable |
| buf_data | output | DATA_W | Receive buffer contents |
| stat_byte | output | 8 | Status byte |
| irq_full | output | 1 | Buffer-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| asm_en | output | 1 | Assembler may deliver characters |

## Verification
The assertions assume that each of the following occupies a cycle of its own, apart from every other one:
- an offered character (`rx_valid`) or break (`rx_brk`),
- a data read,
- a status read,
- a status write.

They also assume that `rx_valid` and `rx_brk` never pulse together. The bench applies every strobe as a single-cycle pulse from its own task and waits at least one idle cycle between tasks, so these overlaps never occur. The freeze and overrun checks rest on the processor reading data before status, which every scenario follows.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   // Status byte; field order is the register bit order (bit 7 first)
   typedef struct packed {
      logic bf;    // buffer full
      logic oe;    // overrun
      logic pe;    // parity error
      logic fe;    // frame error
      logic fsb;   // sync found / break
      logic mcip;  // match or character in progress
      logic ss;    // sync strip enable
      logic re;    // receiver enable
   } rxs_stat_t;

   localparam int STAT_W = $bits(rxs_stat_t);
   localparam int CTL_W  = 2;
endpackage

// File: rtl/rxs_buffer.sv
module rxs_buffer #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic [LEN_W-1:0]  len_sel,
   output logic [DATA_W-1:0] q
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [CNT_W-1:0]  keep;
   logic [DATA_W-1:0] trimmed;

   assign keep = CNT_W'(DATA_W) - CNT_W'(len_sel);

   for (genvar i = 0; i < DATA_W; i++) begin : g_trim
      assign trimmed[i] = (CNT_W'(i) < keep) ? din[i] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= trimmed;
   end
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags
   import rxs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             rx_perr,
   input  logic             rx_ferr,
   input  logic             rx_sfb,
   input  logic             rx_match,
   input  logic             rx_brk,
   input  logic             rx_busy,
   input  logic             async_mode,
   input  logic             rd_data,
   input  logic             rd_stat,
   input  logic             wr_stat,
   input  logic [CTL_W-1:0] wr_ctl,
   output logic             load,
   output logic             set_full,
   output logic             set_err,
   output logic             asm_ok,
   output rxs_stat_t        stat
);
   logic bf, oe, pe, fe, fsb, ss, re, match_q;
   logic ovr_pend, brk_pend;
   logic accept, ovr_evt, brk_evt, drain, word_bad;

   assign asm_ok   = re & ~oe;
   assign accept   = rx_valid & asm_ok;
   assign load     = accept & ~bf;
   assign ovr_evt  = accept & bf;
   assign brk_evt  = rx_brk & re;
   assign drain    = rd_data & bf;
   assign word_bad = rx_perr | rx_ferr | rx_sfb;

   assign set_full = load & ~word_bad;
   assign set_err  = (load & word_bad) | (brk_evt & ~bf) |
                     (drain & (ovr_pend | brk_pend));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bf <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; fsb <= 1'b0;
         ss <= 1'b0; re <= 1'b0; match_q <= 1'b0;
         ovr_pend <= 1'b0; brk_pend <= 1'b0;
      end else begin
         if (wr_stat) begin
            re <= wr_ctl[0];
            ss <= wr_ctl[1];
         end
         if (load) begin
            bf      <= 1'b1;
            pe      <= rx_perr;
            fe      <= rx_ferr;
            fsb     <= rx_sfb;
            match_q <= rx_match;
         end
         if (ovr_evt)         ovr_pend <= 1'b1;
         if (brk_evt &&  bf)  brk_pend <= 1'b1;
         if (brk_evt && !bf)  fsb      <= 1'b1;
         if (drain) begin
            bf       <= 1'b0;
            ovr_pend <= 1'b0;
            brk_pend <= 1'b0;
            if (ovr_pend) oe  <= 1'b1;
            if (brk_pend) fsb <= 1'b1;
         end
         if (rd_stat) oe <= 1'b0;
      end
   end

   always_comb begin
      stat.bf   = bf;
      stat.oe   = oe;
      stat.pe   = pe;
      stat.fe   = fe;
      stat.fsb  = fsb;
      stat.mcip = async_mode ? rx_busy : match_q;
      stat.ss   = ss;
      stat.re   = re;
   end
endmodule

// File: rtl/rxs_irq.sv
module rxs_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_full,
   input  logic set_err,
   input  logic rd_data,
   input  logic rd_stat,
   input  logic full_ie,
   input  logic err_ie,
   output logic irq_full,
   output logic irq_err
);
   logic full_req, err_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_req <= 1'b0;
         err_req  <= 1'b0;
      end else begin
         if (set_full)     full_req <= 1'b1;
         else if (rd_data) full_req <= 1'b0;
         if (set_err)      err_req  <= 1'b1;
         else if (rd_stat) err_req  <= 1'b0;
      end
   end

   // error requests fall back to the buffer-full line when masked
   assign irq_err  = err_ie & err_req;
   assign irq_full = full_ie & (full_req | (err_req & ~err_ie));
endmodule

// File: rtl/rxstat_ctrl.sv
module rxstat_ctrl
   import rxs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_sfb,
   input  logic              rx_match,
   input  logic              rx_brk,
   input  logic              rx_busy,
   input  logic              async_mode,
   input  logic [LEN_W-1:0]  len_sel,
   input  logic              rd_data,
   input  logic              rd_stat,
   input  logic              wr_stat,
   input  logic [1:0]        wr_ctl,
   input  logic              full_ie,
   input  logic              err_ie,
   output logic [DATA_W-1:0] buf_data,
   output logic [7:0]        stat_byte,
   output logic              irq_full,
   output logic              irq_err,
   output logic              asm_en
);
   localparam int MIN_KEEP = DATA_W - (2**LEN_W - 1);

   if (LEN_W < 1 || LEN_W > 3) begin : g_bad_len
      $error("rxstat_ctrl: LEN_W must be 1..3");
   end
   if (MIN_KEEP < 1 || DATA_W > 16) begin : g_bad_width
      $error("rxstat_ctrl: DATA_W too small for LEN_W or above 16");
   end
   if (STAT_W != 8) begin : g_bad_stat
      $error("rxstat_ctrl: status byte must be 8 bits");
   end

   logic      load, set_full, set_err, asm_ok;
   rxs_stat_t stat;

   rxs_buffer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .load(load), .din(rx_data),
      .len_sel(len_sel), .q(buf_data)
   );

   rxs_flags u_flags (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_sfb(rx_sfb), .rx_match(rx_match),
      .rx_brk(rx_brk), .rx_busy(rx_busy), .async_mode(async_mode),
      .rd_data(rd_data), .rd_stat(rd_stat), .wr_stat(wr_stat),
      .wr_ctl(wr_ctl), .load(load), .set_full(set_full),
      .set_err(set_err), .asm_ok(asm_ok), .stat(stat)
   );

   rxs_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set_full(set_full), .set_err(set_err),
      .rd_data(rd_data), .rd_stat(rd_stat), .full_ie(full_ie),
      .err_ie(err_ie), .irq_full(irq_full), .irq_err(irq_err)
   );

   assign stat_byte = stat;
   assign asm_en    = asm_ok;
endmodule

// File: rtl/rxstat_ctrl_chk.sv
module rxstat_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rd_data,
   input logic              rd_stat,
   input logic              err_ie,
   input logic [DATA_W-1:0] buf_data,
   input logic [7:0]        stat_byte,
   input logic              irq_err,
   input logic              asm_en
);
   assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && asm_en && !stat_byte[7]) |=> stat_byte[7]);

   assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_byte[7] && !rd_data && !rd_stat)
      |=> ($stable(stat_byte[6:3]) && $stable(buf_data)));

   assert_oe_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat_byte[6]) && err_ie) |-> irq_err);

   assert_oe_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[6] |-> !stat_byte[7]);

   assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[6] |-> !asm_en);

   assert_oe_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |=> !stat_byte[6]);
endmodule

bind rxstat_ctrl rxstat_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_data(rd_data),
   .rd_stat(rd_stat), .err_ie(err_ie), .buf_data(buf_data),
   .stat_byte(stat_byte), .irq_err(irq_err), .asm_en(asm_en)
);

// File: tb/tb_rxstat_ctrl.sv
`timescale 1ns/1ps
module tb_rxstat_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 0, rx_perr = 0, rx_ferr = 0, rx_sfb = 0;
   logic       rx_match = 0, rx_brk = 0, rx_busy = 0, async_mode = 0;
   logic [7:0] rx_data = '0;
   logic [1:0] len_sel = '0;
   logic       rd_data = 0, rd_stat = 0, wr_stat = 0;
   logic [1:0] wr_ctl = '0;
   logic       full_ie = 0, err_ie = 0;
   logic [7:0] buf_data, stat_byte;
   logic       irq_full, irq_err, asm_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   rxstat_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_sfb(rx_sfb),
      .rx_match(rx_match), .rx_brk(rx_brk), .rx_busy(rx_busy),
      .async_mode(async_mode), .len_sel(len_sel), .rd_data(rd_data),
      .rd_stat(rd_stat), .wr_stat(wr_stat), .wr_ctl(wr_ctl),
      .full_ie(full_ie), .err_ie(err_ie), .buf_data(buf_data),
      .stat_byte(stat_byte), .irq_full(irq_full), .irq_err(irq_err),
      .asm_en(asm_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic word(input logic [7:0] d, input logic pe, input logic fe,
                       input logic sfb, input logic m);
      @(negedge clk);
      rx_valid = 1; rx_data = d; rx_perr = pe; rx_ferr = fe; rx_sfb = sfb; rx_match = m;
      @(negedge clk);
      rx_valid = 0; rx_perr = 0; rx_ferr = 0; rx_sfb = 0; rx_match = 0;
   endtask

   task automatic brk();
      @(negedge clk); rx_brk = 1;
      @(negedge clk); rx_brk = 0;
   endtask

   task automatic rdd();
      @(negedge clk); rd_data = 1;
      @(negedge clk); rd_data = 0;
   endtask

   task automatic rds();
      @(negedge clk); rd_stat = 1;
      @(negedge clk); rd_stat = 0;
   endtask

   task automatic wrs(input logic [1:0] v);
      @(negedge clk); wr_stat = 1; wr_ctl = v;
      @(negedge clk); wr_stat = 0;
   endtask

   task automatic t_reset();
      chk("R1 status", stat_byte, 8'h00);
      chk("R1 irq_full", irq_full, 0);
      chk("R1 irq_err", irq_err, 0);
      chk("R1 asm_en", asm_en, 0);
      word(8'h5A, 0, 0, 0, 0);
      chk("R1 no accept", stat_byte, 8'h00);
   endtask

   task automatic t_write();
      wrs(2'b11);
      chk("R2 write both", stat_byte, 8'h03);
      wrs(2'b01);
      chk("R2 write re only", stat_byte, 8'h01);
   endtask

   task automatic t_transfer();
      full_ie = 1; err_ie = 1;
      len_sel = 2'b00; word(8'hA5, 0, 0, 0, 0);
      chk("R3 data len8", buf_data, 8'hA5);
      chk("R3 status", stat_byte, 8'h81);
      chk("R9 clean irq_full", irq_full, 1);
      chk("R9 clean irq_err", irq_err, 0);
      rdd();
      chk("R4 bf clear", stat_byte, 8'h01);
      chk("R9 full cleared", irq_full, 0);
      len_sel = 2'b01; word(8'hFF, 0, 0, 0, 0);
      chk("R3 data len7", buf_data, 8'h7F); rdd();
      len_sel = 2'b10; word(8'hFF, 0, 0, 0, 0);
      chk("R3 data len6", buf_data, 8'h3F); rdd();
      len_sel = 2'b11; word(8'hFF, 0, 0, 0, 0);
      chk("R3 data len5", buf_data, 8'h1F); rdd();
      len_sel = 2'b00;
   endtask

   task automatic t_overrun();
      word(8'h11, 1, 0, 0, 0);
      chk("R3 pe captured", stat_byte, 8'hA1);
      chk("R9 err irq_err", irq_err, 1);
      chk("R9 err no irq_full", irq_full, 0);
      word(8'h22, 0, 0, 0, 0);
      chk("R4 frozen data", buf_data, 8'h11);
      chk("R5 oe not yet", stat_byte, 8'hA1);
      rdd();
      chk("R5 oe after read", stat_byte, 8'h61);
      chk("R6 gate low", asm_en, 0);
      word(8'h33, 0, 0, 0, 0);
      chk("R6 ignored stat", stat_byte, 8'h61);
      chk("R6 ignored data", buf_data, 8'h11);
      rds();
      chk("R6 oe cleared", stat_byte, 8'h21);
      chk("R6 gate high", asm_en, 1);
      chk("R9 err cleared", irq_err, 0);
   endtask

   task automatic t_brk_full();
      word(8'h44, 0, 0, 0, 0);
      chk("R7 pre", stat_byte, 8'h81);
      brk();
      chk("R7 held", stat_byte, 8'h81);
      rdd();
      chk("R7 brk after read, no oe", stat_byte, 8'h09);
      chk("R7 err irq", irq_err, 1);
      rds();
      chk("R7 irq cleared", irq_err, 0);
   endtask

   task automatic t_both();
      word(8'h55, 0, 0, 0, 0);
      word(8'h66, 0, 0, 0, 0);
      brk();
      chk("R8 held", stat_byte, 8'h81);
      rdd();
      chk("R8 both set", stat_byte, 8'h49);
      chk("R8 data kept", buf_data, 8'h55);
      rds();
      chk("R8 oe cleared", stat_byte, 8'h09);
   endtask

   task automatic t_fallback();
      err_ie = 0; full_ie = 1;
      word(8'h77, 0, 1, 0, 0);
      chk("R10 status", stat_byte, 8'h91);
      chk("R10 on full line", irq_full, 1);
      chk("R10 err line low", irq_err, 0);
      rdd();
      chk("R10 after data read", irq_full, 1);
      rds();
      chk("R10 after status read", irq_full, 0);
   endtask

   task automatic t_mask();
      full_ie = 0; err_ie = 0;
      word(8'h12, 0, 0, 0, 0);
      chk("R11 masked", irq_full, 0);
      chk("R11 flags", stat_byte, 8'h81);
      idle(); full_ie = 1; idle();
      chk("R11 unmasked", irq_full, 1);
      rdd();
   endtask

   task automatic t_mcip();
      async_mode = 0;
      word(8'h3C, 0, 0, 0, 1);
      chk("R12 match latched", stat_byte, 8'h85);
      rdd();
      chk("R12 match held", stat_byte, 8'h05);
      word(8'h3D, 0, 0, 0, 0);
      idle(); async_mode = 1; rx_busy = 1; idle();
      chk("R12 busy live frozen", stat_byte, 8'h85);
      rx_busy = 0; idle();
      chk("R12 busy low", stat_byte, 8'h81);
      rdd();
      async_mode = 0;
   endtask

   task automatic t_disable();
      wrs(2'b00);
      chk("R13 asm_en", asm_en, 0);
      word(8'h99, 0, 0, 0, 0);
      brk();
      chk("R13 stat", stat_byte, 8'h00);
      chk("R13 data", buf_data, 8'h3D);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle();
      t_reset();
      t_write();
      t_transfer();
      t_overrun();
      t_brk_full();
      t_both();
      t_fallback();
      t_mask();
      t_mcip();
      t_disable();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule